// File: doc/BRIEF.md
# Multi-Sector Erase Collector

This block gathers the sectors of a multi-sector erase and then runs their erases one after another. The first sector-erase command opens an acceptance window that lasts a fixed number of clock cycles. While the window is open, each further sector-erase command marks one more sector in a bitmap and restarts the window at its full length. When no accepted command arrives for a whole window, the window closes and the block erases every marked sector.

Each marked sector is handled in two steps, lowest sector index first. The first step fills the sector with zeros and verifies it. The second step erases it electrically. Each step is handed to the physical erase engine as a request that stays asserted until the engine returns a one-cycle done pulse.

A command of any other kind during the window throws away the whole collection and returns the block to idle. An erase-suspend command during the window is passed on as a one-cycle pulse and leaves the collection as it was. Command unlock decoding is done upstream, and suspend handling is done downstream.

Top module: `sector_erase_queue`

## Requirements
- R1: While reset is asserted and after it is released, `window_open_o`, `busy_o`, `suspend_o` and `erase_req_o` are all 0.
- R2: A sector-erase command (`cmd_kind_i` = 2'b01) accepted while idle sets `window_open_o` and `busy_o` in the next cycle.
- R3: Every accepted sector-erase command restarts the window. `window_open_o` stays high for WINDOW_CYC cycles after the last accepted command and falls on the following edge. `erase_req_o` rises on that same edge and is never high while the window is open.
- R4: Marked sectors are erased in ascending index order, whatever order they were added in. Each sector first gets a request with `erase_phase_o` = 0 (zero-fill and verify), then one with `erase_phase_o` = 1 (electrical erase). A request holds its sector and phase until `erase_done_i` is sampled high at a clock edge.
- R5: A command of kind 2'b00 or 2'b11 during the window clears every marked sector and drives `window_open_o` and `busy_o` low in the next cycle. No erase request follows.
- R6: An erase-suspend command (`cmd_kind_i` = 2'b10) during the window gives a one-cycle pulse on `suspend_o` in the next cycle. It leaves the marked set unchanged and does not restart the window.
- R7: Adding a sector that is already marked erases that sector only once. It still restarts the window.
- R8: `busy_o` stays high until the done of the last sector's phase-1 request and falls on that edge.
- R9: Commands that arrive after the window has closed, while erasing is under way, are ignored.
- R10: Any subset of sectors can be selected, up to all N_SECT sectors.
- R11: While idle, suspend and other commands have no effect: `busy_o`, `window_open_o` and `suspend_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | A decoded command is present this cycle |
| cmd_kind_i | input | 2 | Command kind: 01 sector erase, 10 erase suspend, 00/11 other |
| cmd_sector_i | input | SEC_W | Sector index carried with a sector-erase command |
| erase_done_i | input | 1 | One-cycle completion pulse for the current request |
| window_open_o | output | 1 | The acceptance window is open |
| busy_o | output | 1 | The block is collecting sectors or erasing them |
| suspend_o | output | 1 | One-cycle pulse for a suspend received inside the window |
| erase_req_o | output | 1 | Request for one erase step |
| erase_sector_o | output | SEC_W | Sector of the current request |
| erase_phase_o | output | 1 | 0 = zero-fill and verify, 1 = electrical erase |

## Verification
Every result is registered. A command that is present at a rising edge shows up in the window, busy and suspend outputs one cycle later. The window closes, and the first request appears, on the edge WINDOW_CYC cycles after the edge that accepted the last command. A done pulse moves the request on to the next phase or sector at the edge that samples it. The bench drives and samples on falling edges and counts whole cycles from the accepting edge, so every check lands in the first cycle in which the result is due, and in the cycle just before it where a window boundary is concerned.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_COLLECT, ST_ERASE} sq_state_e;
  localparam logic [1:0] CMD_SECT_ERASE = 2'b01;
  localparam logic [1:0] CMD_SUSPEND    = 2'b10;
endpackage

// File: rtl/sq_window_timer.sv
module sq_window_timer #(
  parameter int WINDOW_CYC = 20,
  parameter int CNT_W      = $clog2(WINDOW_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WINDOW_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= LOAD_VAL;
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  AST_RELOAD_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == LOAD_VAL); // R3
endmodule

// File: rtl/sq_sector_map.sv
module sq_sector_map #(
  parameter int N_SECT = 8,
  parameter int SEC_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [SEC_W-1:0]  set_idx_i,
  input  logic              clr_one_i,
  input  logic [SEC_W-1:0]  clr_idx_i,
  input  logic              clr_all_i,
  output logic [N_SECT-1:0] map_o,
  output logic [SEC_W-1:0]  low_idx_o,
  output logic              last_o
);
  for (genvar g = 0; g < N_SECT; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      map_o[g] <= 1'b0;
      else if (clr_all_i)                               map_o[g] <= 1'b0;
      else if (set_i && set_idx_i == SEC_W'(g))         map_o[g] <= 1'b1;
      else if (clr_one_i && clr_idx_i == SEC_W'(g))     map_o[g] <= 1'b0;
    end
  end

  // lowest marked index wins
  always_comb begin
    low_idx_o = '0;
    for (int i = N_SECT - 1; i >= 0; i--) begin
      if (map_o[i]) low_idx_o = SEC_W'(i);
    end
  end

  assign last_o = (map_o != '0) && ((map_o & (map_o - 1'b1)) == '0);

  AST_LOW_IS_MARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (map_o != '0) |-> map_o[low_idx_o]); // R4
  AST_NONE_BELOW_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (map_o & ((N_SECT'(1) << low_idx_o) - 1'b1)) == '0); // R4
endmodule

// File: rtl/sector_erase_queue.sv
module sector_erase_queue
  import sq_pkg::*;
#(
  parameter int N_SECT     = 8,
  parameter int WINDOW_CYC = 20,
  localparam int SEC_W     = (N_SECT > 1) ? $clog2(N_SECT) : 1,
  localparam int CNT_W     = $clog2(WINDOW_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_kind_i,
  input  logic [SEC_W-1:0] cmd_sector_i,
  input  logic             erase_done_i,
  output logic             window_open_o,
  output logic             busy_o,
  output logic             suspend_o,
  output logic             erase_req_o,
  output logic [SEC_W-1:0] erase_sector_o,
  output logic             erase_phase_o
);
  sq_state_e         state_q;
  logic              phase_q, susp_q;
  logic              in_idle, in_coll, in_erase;
  logic              is_se, is_susp, is_foreign;
  logic              accept, abort, expire, fin;
  logic              tmr_exp, last_sect;
  logic [N_SECT-1:0] map;
  logic [SEC_W-1:0]  low_idx;

  assign in_idle    = (state_q == ST_IDLE);
  assign in_coll    = (state_q == ST_COLLECT);
  assign in_erase   = (state_q == ST_ERASE);
  assign is_se      = cmd_valid_i && (cmd_kind_i == CMD_SECT_ERASE);
  assign is_susp    = cmd_valid_i && (cmd_kind_i == CMD_SUSPEND);
  assign is_foreign = cmd_valid_i && !is_se && !is_susp;
  assign accept     = (in_idle || in_coll) && is_se;
  assign abort      = in_coll && is_foreign;
  assign expire     = in_coll && tmr_exp && !is_se && !is_foreign;
  assign fin        = in_erase && erase_done_i && phase_q;

  sq_window_timer #(.WINDOW_CYC(WINDOW_CYC), .CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .run_i     (in_coll),
    .expired_o (tmr_exp)
  );

  sq_sector_map #(.N_SECT(N_SECT), .SEC_W(SEC_W)) u_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (accept),
    .set_idx_i (cmd_sector_i),
    .clr_one_i (fin),
    .clr_idx_i (low_idx),
    .clr_all_i (abort),
    .map_o     (map),
    .low_idx_o (low_idx),
    .last_o    (last_sect)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= 1'b0;
      susp_q  <= 1'b0;
    end else begin
      susp_q <= in_coll && is_susp;
      unique case (state_q)
        ST_IDLE:    if (accept) state_q <= ST_COLLECT;
        ST_COLLECT: begin
          if (abort)       state_q <= ST_IDLE;
          else if (expire) state_q <= ST_ERASE;
        end
        ST_ERASE: begin
          if (erase_done_i) phase_q <= ~phase_q;
          if (fin && last_sect) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign window_open_o  = in_coll;
  assign busy_o         = !in_idle;
  assign suspend_o      = susp_q;
  assign erase_req_o    = in_erase;
  assign erase_sector_o = low_idx;
  assign erase_phase_o  = phase_q;

  AST_IDLE_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_idle |-> (map == '0)); // R8
  AST_ABORT_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |=> (!window_open_o && !busy_o && map == '0)); // R5
  AST_NO_REQ_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    window_open_o |-> !erase_req_o); // R3
  AST_SUSP_KEEPS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_coll && is_susp) |=> (map == $past(map))); // R6
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_req_o && !erase_done_i) |=>
      (erase_req_o && $stable(erase_sector_o) && $stable(erase_phase_o))); // R4
  AST_ERASE_IGNORES_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_erase && !erase_done_i) |=> $stable(map)); // R9
  AST_REQ_IMPLIES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_o |-> busy_o); // R8
endmodule

// File: tb/sector_erase_queue_tb.sv
`timescale 1ns/1ps
module sector_erase_queue_tb;
  localparam int N = 8;
  localparam int W = 20;
  localparam logic [1:0] K_SE = 2'b01, K_SUSP = 2'b10, K_OTH0 = 2'b00, K_OTH3 = 2'b11;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cmd_valid = 1'b0, done = 1'b0;
  logic [1:0] cmd_kind = 2'b00;
  logic [2:0] cmd_sector = 3'd0;
  logic win, busy, susp, req, phase;
  logic [2:0] sect;
  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sector_erase_queue #(.N_SECT(N), .WINDOW_CYC(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_kind_i(cmd_kind),
    .cmd_sector_i(cmd_sector), .erase_done_i(done), .window_open_o(win),
    .busy_o(busy), .suspend_o(susp), .erase_req_o(req),
    .erase_sector_o(sect), .erase_phase_o(phase)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] k, input int s);
    cmd_valid = 1'b1; cmd_kind = k; cmd_sector = 3'(s);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic idle_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic serve(input logic [N-1:0] mask, input string tag);
    for (int i = 0; i < N; i++) begin
      if (mask[i]) begin
        for (int ph = 0; ph < 2; ph++) begin
          chk(req == 1'b1, {tag, " R4 req"}, req, 1);
          chk(sect == 3'(i), {tag, " R4 sector order"}, sect, i);
          chk(phase == 1'(ph), {tag, " R4 phase"}, phase, ph);
          if (ph == 0) begin
            idle_n(1);
            chk(req == 1'b1 && sect == 3'(i), {tag, " R4 hold without done"}, sect, i);
          end
          chk(busy == 1'b1, {tag, " R8 busy before last done"}, busy, 1);
          done = 1'b1;
          @(negedge clk);
          done = 1'b0;
        end
      end
    end
    chk(busy == 1'b0, {tag, " R8 busy falls after last done"}, busy, 0);
    chk(req == 1'b0, {tag, " R8 no req after last"}, req, 0);
  endtask

  task automatic t_reset();
    chk(win == 0 && busy == 0 && susp == 0 && req == 0, "R1 outputs in reset",
        {win, busy, susp, req}, 0);
    rst_ni = 1'b1;
    idle_n(2);
    chk(win == 0 && busy == 0 && susp == 0 && req == 0, "R1 outputs after reset",
        {win, busy, susp, req}, 0);
  endtask

  task automatic t_single();
    send(K_SE, 3);
    chk(win == 1'b1, "R2 window opens", win, 1);
    chk(busy == 1'b1, "R2 busy rises", busy, 1);
    idle_n(W - 1);
    chk(win == 1'b1, "R3 window still open on last cycle", win, 1);
    chk(req == 1'b0, "R3 no req in window", req, 0);
    idle_n(1);
    chk(win == 1'b0, "R3 window closed", win, 0);
    chk(req == 1'b1, "R3 req at close", req, 1);
    serve(8'h08, "single");
  endtask

  task automatic t_multi();
    send(K_SE, 6);
    idle_n(5);
    send(K_SE, 1);
    idle_n(W - 2);
    chk(win == 1'b1, "R3 window restarted by second command", win, 1);
    send(K_SE, 4);
    send(K_SE, 1);
    idle_n(W - 1);
    chk(win == 1'b1, "R7 repeat restarts window", win, 1);
    idle_n(1);
    chk(win == 1'b0, "R3 closes after last accept", win, 0);
    send(K_SE, 0);
    chk(win == 1'b0, "R9 late command does not reopen", win, 0);
    serve(8'b0101_0010, "multi R7 R9");
  endtask

  task automatic t_all();
    for (int s = N - 1; s >= 0; s--) send(K_SE, s);
    idle_n(W);
    serve(8'hFF, "all R10");
  endtask

  task automatic t_abort();
    send(K_SE, 2);
    send(K_SE, 5);
    send(K_OTH0, 0);
    chk(win == 1'b0, "R5 window closed by foreign", win, 0);
    chk(busy == 1'b0, "R5 idle after foreign", busy, 0);
    idle_n(W + 2);
    chk(req == 1'b0 && busy == 1'b0, "R5 no erase after abort", req, 0);
    send(K_SE, 1);
    send(K_OTH3, 7);
    chk(busy == 1'b0, "R5 kind 3 aborts", busy, 0);
    send(K_SE, 7);
    idle_n(W);
    serve(8'h80, "abort R5 cleared");
  endtask

  task automatic t_suspend();
    send(K_SE, 3);
    idle_n(2);
    send(K_SUSP, 0);
    chk(susp == 1'b1, "R6 suspend pulse", susp, 1);
    chk(win == 1'b1, "R6 window kept", win, 1);
    idle_n(1);
    chk(susp == 1'b0, "R6 pulse one cycle", susp, 0);
    idle_n(W - 5);
    chk(win == 1'b1, "R6 window before close", win, 1);
    idle_n(1);
    chk(win == 1'b0, "R6 suspend did not restart window", win, 0);
    serve(8'h08, "suspend R6");
  endtask

  task automatic t_idle();
    send(K_SUSP, 0);
    chk(susp == 1'b0 && busy == 1'b0, "R11 suspend in idle", {susp, busy}, 0);
    send(K_OTH0, 3);
    chk(busy == 1'b0 && win == 1'b0, "R11 other in idle", {busy, win}, 0);
    idle_n(3);
    chk(req == 1'b0, "R11 no req from idle commands", req, 0);
  endtask

  initial begin
    idle_n(3);
    t_reset();
    t_single();
    t_multi();
    t_all();
    t_abort();
    t_suspend();
    t_idle();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R1-run: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule